// File: doc/BRIEF.md
# Cache-Line Burst Bus Controller

This block connects a cache to a 64-bit external data bus. The cache side issues one of four requests: a single read, a single write, a line fill or a line write-back. Single accesses move up to eight bytes in one data beat, with byte enables selecting the active lanes. Line transfers always move a whole 32-byte line as a burst of four 64-bit beats. The cache supplies a write-back line, and receives a fill line, as one 256-bit word.

Each operation starts with a one-cycle address strobe. A data phase follows, and each beat of it completes only when the bus raises its ready input, so the bus can insert any number of wait states. A one-cycle done pulse marks the end of the operation. No new request is taken while an operation is in flight.

Top module: `line_burst_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `bus_start` and `bus_dphase` are all low.
- R2: A request seen while idle is taken at that clock edge. In the next cycle `bus_start` is high for exactly one cycle, with `bus_write` = `req_op[0]` and `bus_burst` = `req_op[1]`. The op codes are 0 single read, 1 single write, 2 line fill and 3 line write-back.
- R3: At the address strobe, `bus_addr` is the request address with its low 5 bits cleared for a line transfer, or with its low 3 bits cleared for a single access.
- R4: A line transfer runs exactly four data beats. During beat k (k = 0..3) `bus_addr` equals the line base plus 8*k.
- R5: While `bus_ready` is low in the data phase, the beat does not advance: `bus_dphase` stays high and `bus_addr` holds.
- R6: During beat k of a write-back, `bus_wdata` is bits [64k+63:64k] of the captured line and `bus_be` is 8'hFF.
- R7: After a fill, bits [64k+63:64k] of `rsp_line` hold the `bus_rdata` value present at the ready edge of beat k.
- R8: A single access runs exactly one beat with `bus_burst` low and `bus_be` equal to the captured `req_be`. For a write, `bus_wdata` is the captured `req_wdata`.
- R9: After a single read, `rsp_data` equals the `bus_rdata` of the ready edge, with every byte lane whose enable bit is clear forced to zero. Bit i of `req_be` enables byte lane i, bits [8i+7:8i].
- R10: `done` is high for exactly the one cycle after the ready edge of the final beat, and in that cycle `busy` is low.
- R11: A request raised while `busy` is high, and dropped before `done`, has no effect: no extra address strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache request present |
| req_op | input | 2 | 0 single read, 1 single write, 2 line fill, 3 line write-back |
| req_addr | input | 32 | Byte address of the request |
| req_be | input | 8 | Byte enables for a single access |
| req_wdata | input | 64 | Write data for a single write |
| req_wline | input | 256 | Line for a write-back |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Lane-masked single-read result |
| rsp_line | output | 256 | Filled line |
| bus_start | output | 1 | Address strobe |
| bus_addr | output | 32 | Bus address; during a burst it steps by beat |
| bus_write | output | 1 | Cycle direction, high for writes |
| bus_burst | output | 1 | Four-beat line cycle |
| bus_be | output | 8 | Bus byte enables |
| bus_wdata | output | 64 | Bus write data |
| bus_dphase | output | 1 | Data phase, a beat is pending |
| bus_ready | input | 1 | Beat completes at this edge |
| bus_rdata | input | 64 | Bus read data |

## Verification
A wrong beat counter shows up at the ports within one cycle: `bus_addr` steps to the wrong quadword, or `done` arrives after too few or too many ready edges. A wrong captured op shows up at the address strobe through `bus_write`, `bus_burst` or `bus_be`. A fault in a lane mask or in a line slot shows up in `rsp_data` or `rsp_line` in the `done` cycle. The sweep covers every op, several misaligned addresses, four wait-state patterns and all 256 byte-enable values.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    OP_RD1   = 2'd0,
    OP_WR1   = 2'd1,
    OP_FILL  = 2'd2,
    OP_WBACK = 2'd3
  } lbc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } lbc_st_e;

  function automatic logic op_is_burst(input lbc_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_write(input lbc_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int BW        = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  lbc_op_e       req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          bus_ready,
  output logic          accept,
  output logic          beat_done,
  output logic [BW-1:0] beat_idx,
  output lbc_op_e       cur_op,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_dphase,
  output logic          busy,
  output logic          done
);
  localparam int OFF_Q = $clog2(BEAT_BYTES);
  localparam int OFF_L = $clog2(BEAT_BYTES * BEATS);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  lbc_st_e       st_q;
  logic [BW-1:0] beat_q;
  logic [AW-1:0] base_q;
  lbc_op_e       op_q;
  logic          done_q;
  logic          final_beat;

  // Clears the offset bits below the transfer size.
  function automatic logic [AW-1:0] base_of(input lbc_op_e op, input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = op_is_burst(op) ? ~((AW'(1) << OFF_L) - AW'(1)) : ~((AW'(1) << OFF_Q) - AW'(1));
    return a & m;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [BW-1:0] k);
    return b + (AW'(k) << OFF_Q);
  endfunction

  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign bus_dphase = (st_q == ST_DATA);
  assign bus_start  = (st_q == ST_ADDR);
  assign beat_done  = bus_dphase && bus_ready;
  assign final_beat = op_is_burst(op_q) ? (beat_q == LAST) : 1'b1;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign beat_idx   = beat_q;
  assign cur_op     = op_q;
  assign bus_addr   = beat_addr(base_q, beat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      base_q <= '0;
      op_q   <= OP_RD1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          op_q   <= req_op;
          base_q <= base_of(req_op, req_addr);
          beat_q <= '0;
          st_q   <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: if (bus_ready) begin
          if (final_beat) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + BW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_accept_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> bus_start);
  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (!bus_start && bus_dphase));
  p_line_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && op_is_burst(op_q)) |-> (bus_addr[OFF_L-1:0] == '0));
  p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && busy && !done && $past(bus_start) == 1'b0 && bus_dphase && op_is_burst(op_q) && beat_q != LAST)
      |=> (bus_addr == $past(bus_addr) + AW'(BEAT_BYTES)));
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dphase && !bus_ready) |=> (bus_dphase && $stable(bus_addr)));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/lbc_line_buf.sv
module lbc_line_buf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int BW     = $clog2(BEATS),
  localparam int LINE_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_line,
  input  logic [LINE_W-1:0] wline,
  input  logic              cap_en,
  input  logic [BW-1:0]     idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [LINE_W-1:0] line_q,
  output logic [DATA_W-1:0] beat_word
);
  logic [DATA_W-1:0] slot_q [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (load_line) begin
        slot_q[g] <= wline[g*DATA_W +: DATA_W];
      end else if (cap_en && (idx == BW'(g))) begin
        slot_q[g] <= rdata;
      end
    end
    assign line_q[g*DATA_W +: DATA_W] = slot_q[g];
  end

  assign beat_word = slot_q[idx];

  p_load_cap_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_line && cap_en));
  p_cap_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !load_line) |=> (line_q[$past(idx)*DATA_W +: DATA_W] == $past(rdata)));
endmodule

// File: rtl/lbc_single.sv
module lbc_single #(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NB-1:0]     be,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata_q,
  output logic [NB-1:0]     be_q,
  output logic [DATA_W-1:0] rsp_data
);
  // Spreads one enable bit over each byte lane.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [NB-1:0] e);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < NB; i++) m[i*8 +: 8] = {8{e[i]}};
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q  <= '0;
      be_q     <= '0;
      rsp_data <= '0;
    end else begin
      if (load) begin
        wdata_q <= wdata;
        be_q    <= be;
      end
      if (cap_en) rsp_data <= rdata & lane_mask(be_q);
    end
  end

  p_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !load) |=> ((rsp_data & ~lane_mask(be_q)) == '0));
endmodule

// File: rtl/line_burst_ctrl.sv
module line_burst_ctrl
  import lbc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int DATA_W    = BEAT_BYTES * 8,
  localparam int LINE_W    = DATA_W * BEATS,
  localparam int BW        = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [BEAT_BYTES-1:0] req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LINE_W-1:0] req_wline,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_data,
  output logic [LINE_W-1:0] rsp_line,
  output logic              bus_start,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_write,
  output logic              bus_burst,
  output logic [BEAT_BYTES-1:0] bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_dphase,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  lbc_op_e       op_in;
  lbc_op_e       cur_op;
  logic          accept;
  logic          beat_done;
  logic [BW-1:0] beat_idx;
  logic          load_line;
  logic          cap_line;
  logic          load_single;
  logic          cap_single;
  logic [DATA_W-1:0] line_word;
  logic [DATA_W-1:0] single_wdata;
  logic [BEAT_BYTES-1:0] single_be;

  assign op_in = lbc_op_e'(req_op);

  lbc_ctrl #(.AW(AW), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_in),
    .req_addr(req_addr), .bus_ready(bus_ready), .accept(accept),
    .beat_done(beat_done), .beat_idx(beat_idx), .cur_op(cur_op),
    .bus_start(bus_start), .bus_addr(bus_addr), .bus_dphase(bus_dphase),
    .busy(busy), .done(done)
  );

  assign load_line   = accept && (op_in == OP_WBACK);
  assign cap_line    = beat_done && (cur_op == OP_FILL);
  assign load_single = accept && !op_is_burst(op_in);
  assign cap_single  = beat_done && (cur_op == OP_RD1);

  lbc_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_line (
    .clk(clk), .rst_n(rst_n), .load_line(load_line), .wline(req_wline),
    .cap_en(cap_line), .idx(beat_idx), .rdata(bus_rdata),
    .line_q(rsp_line), .beat_word(line_word)
  );

  lbc_single #(.DATA_W(DATA_W)) u_single (
    .clk(clk), .rst_n(rst_n), .load(load_single), .wdata(req_wdata),
    .be(req_be), .cap_en(cap_single), .rdata(bus_rdata),
    .wdata_q(single_wdata), .be_q(single_be), .rsp_data(rsp_data)
  );

  assign bus_write = op_is_write(cur_op);
  assign bus_burst = op_is_burst(cur_op);
  assign bus_be    = bus_burst ? '1 : single_be;
  assign bus_wdata = bus_burst ? line_word : single_wdata;

  p_no_strobe_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_start) |=> !(bus_start && $past(busy)));
  p_single_one_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !bus_burst) |=> done);
endmodule

// File: tb/line_burst_ctrl_bench.sv
module line_burst_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [1:0]   req_op;
  logic [31:0]  req_addr;
  logic [7:0]   req_be;
  logic [63:0]  req_wdata;
  logic [255:0] req_wline;
  logic         busy, done, bus_start, bus_write, bus_burst, bus_dphase;
  logic [63:0]  rsp_data, bus_wdata, bus_rdata;
  logic [255:0] rsp_line;
  logic [31:0]  bus_addr;
  logic [7:0]   bus_be;
  logic         bus_ready;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  int exp_starts = 0;

  always #2 clk = ~clk;

  line_burst_ctrl u_line_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_wline(req_wline), .busy(busy), .done(done), .rsp_data(rsp_data),
    .rsp_line(rsp_line), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_burst(bus_burst), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_dphase(bus_dphase), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata)
  );

  always @(posedge clk) if (rst_n && bus_start) starts++;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_word(input logic [7:0] s, input int k);
    logic [7:0] kb = 8'(k);
    return {s, 8'hC3, kb, 8'h5A, ~s, kb ^ 8'h11, 8'h96, s ^ 8'h3C};
  endfunction

  function automatic logic [63:0] wr_word(input logic [7:0] s, input int k);
    logic [7:0] kb = 8'(k);
    return {8'h71, s + kb, 8'hE4, kb, s ^ 8'hAA, 8'h0F, kb + 8'h30, s};
  endfunction

  function automatic int waits_for(input int pat, input int k);
    case (pat)
      0: return 0;
      1: return 1;
      2: return k % 2;
      default: return 3 - k;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [7:0] be,
                        input int pat, input bit ign, input logic [7:0] seed);
    int nb;
    logic [31:0] base;
    logic [255:0] wl, fl;
    logic [63:0] m;
    nb   = op[1] ? 4 : 1;
    base = op[1] ? {addr[31:5], 5'b0} : {addr[31:3], 3'b0};
    for (int k = 0; k < 4; k++) begin
      wl[k*64 +: 64] = wr_word(seed, k);
      fl[k*64 +: 64] = rd_word(seed, k);
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_be = be;
    req_wdata = wr_word(seed, 7); req_wline = wl;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_be = ~be; req_wdata = ~req_wdata; req_wline = ~wl;
    chk(bus_start == 1'b1, "R2 strobe", 256'(bus_start), 256'(1));
    chk(bus_write == op[0] && bus_burst == op[1], "R2 kind", 256'({bus_write, bus_burst}), 256'({op[0], op[1]}));
    chk(bus_addr == base, "R3 base", 256'(bus_addr), 256'(base));
    if (op[1]) chk(bus_be == 8'hFF, "R6 be", 256'(bus_be), 256'(8'hFF));
    else chk(bus_be == be, "R8 be", 256'(bus_be), 256'(be));
    @(posedge clk);
    for (int k = 0; k < nb; k++) begin
      for (int w = 0; w < waits_for(pat, k); w++) begin
        @(negedge clk);
        bus_ready = 1'b0;
        if (ign) begin req_valid = 1'b1; req_op = 2'd2; req_addr = ~addr; end
        chk(bus_dphase && bus_addr == base + 32'(8 * k), "R5 wait hold", 256'(bus_addr), 256'(base + 32'(8 * k)));
        @(posedge clk);
      end
      @(negedge clk);
      bus_ready = 1'b1;
      bus_rdata = rd_word(seed, k);
      req_valid = (ign && k != nb - 1);
      chk(bus_dphase && bus_addr == base + 32'(8 * k), "R4 beat addr", 256'(bus_addr), 256'(base + 32'(8 * k)));
      if (op == 2'd3) chk(bus_wdata == wr_word(seed, k), "R6 wdata", 256'(bus_wdata), 256'(wr_word(seed, k)));
      if (op == 2'd1) chk(bus_wdata == wr_word(seed, 7), "R8 wdata", 256'(bus_wdata), 256'(wr_word(seed, 7)));
      @(posedge clk);
    end
    @(negedge clk);
    bus_ready = 1'b0;
    req_valid = 1'b0;
    chk(done && !busy, "R10 done", 256'({done, busy}), 256'(2'b10));
    if (op == 2'd2) chk(rsp_line == fl, "R7 line", rsp_line, fl);
    if (op == 2'd0) begin
      for (int i = 0; i < 8; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
      chk(rsp_data == (rd_word(seed, 0) & m), "R9 lanes", 256'(rsp_data), 256'(rd_word(seed, 0) & m));
    end
    exp_starts++;
    @(posedge clk);
    @(negedge clk);
    chk(!done && !busy && !bus_start, "R10 pulse end", 256'({done, busy, bus_start}), 256'(0));
    chk(starts == exp_starts, "R11 starts", 256'(starts), 256'(exp_starts));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_be = '0;
    req_wdata = '0; req_wline = '0; bus_ready = 1'b0; bus_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !bus_start && !bus_dphase, "R1 reset", 256'({busy, done, bus_start, bus_dphase}), 256'(0));
    rst_n = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 4; p++) begin
          logic [31:0] ad;
          case (a)
            0: ad = 32'h0000_1000;
            1: ad = 32'h0000_1237;
            2: ad = 32'hFFFF_FFE5;
            default: ad = 32'h0000_0008;
          endcase
          run_op(2'(op), ad, 8'(8'h5A + op * 16 + a), p, (p == 3), 8'(op * 16 + a * 4 + p));
        end
    for (int b = 0; b < 256; b++) run_op(2'd0, 32'h0000_2000 + 32'(b), 8'(b), b % 4, 1'b0, 8'(b));
    for (int b = 0; b < 256; b += 37) run_op(2'd1, 32'h0000_3004, 8'(b), 1, 1'b0, 8'(b));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule